// File: doc/BRIEF.md
# Programmable Feedback/Reference Divider Pair with Phase-Frequency Detector

This block is the digital core of a frequency synthesizer loop. A feedback divider counts edges of the oscillator under control. A reference divider counts edges of the crystal clock. Each divider emits a one-cycle terminal pulse once per programmed ratio. A tri-state phase-frequency detector compares the two pulse streams and drives pump-up and pump-down requests. Those requests, together with both divided pulses, are the outputs that the lock monitor downstream consumes.

Everything runs on one system clock. Each source clock reaches the block as a per-cycle tick qualifier (`fb_tick`, `ref_tick`). A divider advances only in cycles where its tick is high.

Ratios are loaded at two points: when the block leaves power-save, and at each terminal count. A ratio written in the middle of a period therefore never produces a shortened or stretched period. A ratio below the legal floor is raised to that floor. A polarity control swaps the meaning of the two detector outputs, to suit loop filters of either sense. While power-save is active (`pwr_on` low), both counters and the detector are held cleared.

Top module: `pll_divpfd`

## Requirements
- R1: `main_ratio` is an unsigned 17-bit binary divide ratio. Values below 4032 are treated as 4032. `fb_div` is a one-cycle pulse after every N-th `fb_tick`, so with `fb_tick` held high the pulses are N clock cycles apart.
- R2: `ref_ratio` is an unsigned 12-bit binary divide ratio. Values below 20 are treated as 20. `ref_div` pulses once every N `ref_tick`s in the same way.
- R3: Ratios are plain binary with bit 0 as the LSB. `main_ratio` with only bit 13 set divides by 8192, and `ref_ratio` with only bit 11 set divides by 2048.
- R4: A ratio changed mid-period is not used until the current period ends at its terminal count. The period in progress keeps the old ratio and the following period uses the new one.
- R5: A divider advances only in clock cycles where its tick input is high.
- R6: With `swap_pol` = 0, a `ref_div` pulse with no pending `fb_div` raises `pump_up` in the next cycle. A following `fb_div` pulse clears it, and `pump_down` stays low throughout.
- R7: With `swap_pol` = 0, an `fb_div` pulse with no pending `ref_div` raises `pump_down` in the same way.
- R8: When `ref_div` and `fb_div` pulse in the same cycle, neither pump output is raised. `pump_up` and `pump_down` are never high together.
- R9: With `swap_pol` = 1, the roles of `pump_up` and `pump_down` are exchanged.
- R10: While `pwr_on` is low, both counters are cleared and no divided pulse or pump output appears. Ratios are re-sampled while `pwr_on` is low and take effect when it returns high.
- R11: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | High = active, low = power-save |
| fb_tick | input | 1 | Feedback clock edge qualifier |
| ref_tick | input | 1 | Crystal clock edge qualifier |
| main_ratio | input | 17 | Feedback divide ratio |
| ref_ratio | input | 12 | Reference divide ratio |
| swap_pol | input | 1 | Detector polarity swap |
| fb_div | output | 1 | Feedback terminal pulse |
| ref_div | output | 1 | Reference terminal pulse |
| pump_up | output | 1 | Pump-up request |
| pump_down | output | 1 | Pump-down request |

## Verification
The bench measures pulse spacing at the floors, at single-bit ratios and at the maximum. A design that skipped clamping, or counted off by one, would show a wrong interval. Changing the ratio mid-period targets the deferred reload: an eager design would produce a shortened first interval. The detector is driven with each source leading in turn, with both sources coinciding, and with the polarity both ways. A wrong tri-state machine would leave a pump stuck high, or raise one on simultaneous edges. Power-save is exercised with both ticks running to confirm that nothing leaks out.

// File: rtl/pll_divpfd_pkg.sv
package pll_divpfd_pkg;
  localparam int MAIN_W   = 17;
  localparam int REF_W    = 12;
  localparam int MAIN_MIN = 4032;
  localparam int REF_MIN  = 20;

  // raise a requested ratio to the legal floor
  function automatic logic [31:0] floor_ratio(input logic [31:0] req, input logic [31:0] lo);
    return (req < lo) ? lo : req;
  endfunction
endpackage

// File: rtl/pll_ratio_div.sv
module pll_ratio_div #(
  parameter int W   = 12,
  parameter int MIN = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  import pll_divpfd_pkg::*;

  logic [W-1:0] cnt, act;
  logic         wrap;
  logic [W-1:0] next_ratio;

  assign next_ratio = W'(floor_ratio(32'(ratio), 32'(MIN)));
  assign wrap       = en && tick && (cnt == act - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      act   <= W'(MIN);
      pulse <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      act   <= next_ratio;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap;
      if (wrap) begin
        cnt <= '0;
        act <= next_ratio;
      end else if (tick) begin
        cnt <= cnt + W'(1);
      end
    end
  end

  a_r1_count_in_range: assert property (@(posedge clk) disable iff (!rst_n) cnt < act);
  a_r2_ratio_floor:    assert property (@(posedge clk) disable iff (!rst_n) act >= W'(MIN));
  a_r4_reload_at_tc:   assert property (@(posedge clk) disable iff (!rst_n)
                         (act != $past(act)) |-> ($past(wrap) || !$past(en)));
  a_r5_hold_no_tick:   assert property (@(posedge clk) disable iff (!rst_n)
                         (en && !tick) |=> $stable(cnt));
  a_r10_idle_quiet:    assert property (@(posedge clk) disable iff (!rst_n) !en |=> !pulse);
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ref_p,
  input  logic fb_p,
  input  logic swap,
  output logic up,
  output logic dn
);
  logic ref_lead, fb_lead;
  logic ref_lead_nx, fb_lead_nx;

  always_comb begin
    ref_lead_nx = ref_lead;
    fb_lead_nx  = fb_lead;
    if (ref_p && fb_p) begin
      ref_lead_nx = 1'b0;
      fb_lead_nx  = 1'b0;
    end else if (ref_p) begin
      ref_lead_nx = !fb_lead;
      fb_lead_nx  = 1'b0;
    end else if (fb_p) begin
      fb_lead_nx  = !ref_lead;
      ref_lead_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_lead <= 1'b0;
      fb_lead  <= 1'b0;
    end else if (!en) begin
      ref_lead <= 1'b0;
      fb_lead  <= 1'b0;
    end else begin
      ref_lead <= ref_lead_nx;
      fb_lead  <= fb_lead_nx;
    end
  end

  assign up = swap ? fb_lead  : ref_lead;
  assign dn = swap ? ref_lead : fb_lead;

  a_r8_never_both:   assert property (@(posedge clk) disable iff (!rst_n) !(up && dn));
  a_r8_coincide:     assert property (@(posedge clk) disable iff (!rst_n)
                       (en && ref_p && fb_p) |=> (!ref_lead && !fb_lead));
  a_r6_ref_first:    assert property (@(posedge clk) disable iff (!rst_n)
                       (en && ref_p && !fb_p && !fb_lead) |=> ref_lead);
  a_r10_pfd_idle:    assert property (@(posedge clk) disable iff (!rst_n) !en |=> (!up && !dn));
endmodule

// File: rtl/pll_divpfd.sv
module pll_divpfd (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_on,
  input  logic        fb_tick,
  input  logic        ref_tick,
  input  logic [16:0] main_ratio,
  input  logic [11:0] ref_ratio,
  input  logic        swap_pol,
  output logic        fb_div,
  output logic        ref_div,
  output logic        pump_up,
  output logic        pump_down
);
  import pll_divpfd_pkg::*;

  pll_ratio_div #(.W(MAIN_W), .MIN(MAIN_MIN)) u_main (
    .clk(clk), .rst_n(rst_n), .en(pwr_on), .tick(fb_tick),
    .ratio(main_ratio), .pulse(fb_div)
  );

  pll_ratio_div #(.W(REF_W), .MIN(REF_MIN)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(pwr_on), .tick(ref_tick),
    .ratio(ref_ratio), .pulse(ref_div)
  );

  pll_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .en(pwr_on), .ref_p(ref_div), .fb_p(fb_div),
    .swap(swap_pol), .up(pump_up), .dn(pump_down)
  );

  a_r11_reset_quiet: assert property (@(posedge clk)
                       !rst_n |-> (!fb_div && !ref_div && !pump_up && !pump_down));
endmodule

// File: tb/tb_pll_divpfd.sv
module tb_pll_divpfd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_on = 1'b0;
  logic        fb_tick = 1'b0;
  logic        ref_tick = 1'b0;
  logic [16:0] main_ratio = 17'd100;
  logic [11:0] ref_ratio = 12'd20;
  logic        swap_pol = 1'b0;
  logic        fb_div, ref_div, pump_up, pump_down;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pll_divpfd dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .fb_tick(fb_tick), .ref_tick(ref_tick),
    .main_ratio(main_ratio), .ref_ratio(ref_ratio), .swap_pol(swap_pol),
    .fb_div(fb_div), .ref_div(ref_div), .pump_up(pump_up), .pump_down(pump_down)
  );

  // requested ref ratio and expected spacing in cycles
  localparam int NV = 6;
  localparam logic [11:0] VREQ [NV] = '{12'd5, 12'd19, 12'd20, 12'd33, 12'h800, 12'hFFF};
  localparam int          VEXP [NV] = '{20, 20, 20, 33, 2048, 4095};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count negedges until the chosen pulse is seen (0 = ref, 1 = fb)
  task automatic wait_pulse(input int which, input int lim, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if ((which == 0 ? ref_div : fb_div) || n >= lim) break;
    end
  endtask

  task automatic restart();
    @(negedge clk); pwr_on = 1'b0; fb_tick = 1'b0; ref_tick = 1'b0;
    repeat (3) @(negedge clk);
    pwr_on = 1'b1;
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 outputs in reset", {fb_div, ref_div, pump_up, pump_down}, 0);
    rst_n = 1'b1;

    // R2/R3 table of reference ratios
    for (int i = 0; i < NV; i++) begin
      ref_ratio = VREQ[i];
      restart();
      ref_tick = 1'b1;
      wait_pulse(0, 5000, n);
      wait_pulse(0, 5000, n);
      check($sformatf("R2 R3 ref spacing for %0d", VREQ[i]), n, VEXP[i]);
    end

    // R1 floor on main ratio
    main_ratio = 17'd100;
    restart(); fb_tick = 1'b1;
    wait_pulse(1, 9000, n); wait_pulse(1, 9000, n);
    check("R1 main floor 4032", n, 4032);

    // R3 main bit 13 only
    main_ratio = 17'h02000;
    restart(); fb_tick = 1'b1;
    wait_pulse(1, 20000, n); wait_pulse(1, 20000, n);
    check("R3 main ratio 8192", n, 8192);

    // R5 tick every other cycle
    ref_ratio = 12'd20;
    restart();
    fork
      begin : gen_tick
        forever begin @(negedge clk); ref_tick = ~ref_tick; end
      end
      begin
        wait_pulse(0, 500, n); wait_pulse(0, 500, n);
      end
    join_any
    disable gen_tick;
    ref_tick = 1'b0;
    check("R5 half-rate ticks", n, 40);

    // R4 deferred reload
    ref_ratio = 12'd20;
    restart(); ref_tick = 1'b1;
    wait_pulse(0, 500, n);
    repeat (5) @(negedge clk);
    ref_ratio = 12'd50;
    wait_pulse(0, 500, n);
    check("R4 current period kept", n + 5, 20);
    wait_pulse(0, 500, n);
    check("R4 next period uses new ratio", n, 50);

    // R6 ref leads, normal polarity
    main_ratio = 17'd4032; ref_ratio = 12'd20; swap_pol = 1'b0;
    restart(); ref_tick = 1'b1;
    wait_pulse(0, 500, n);
    ref_tick = 1'b0;
    @(negedge clk);
    check("R6 up after ref pulse", {pump_up, pump_down}, 2'b10);
    fb_tick = 1'b1;
    wait_pulse(1, 9000, n);
    fb_tick = 1'b0;
    @(negedge clk);
    check("R6 cleared by fb pulse", {pump_up, pump_down}, 2'b00);

    // R7 fb leads
    restart(); fb_tick = 1'b1;
    wait_pulse(1, 9000, n);
    fb_tick = 1'b0;
    @(negedge clk);
    check("R7 down after fb pulse", {pump_up, pump_down}, 2'b01);

    // R9 swapped polarity, ref leads
    swap_pol = 1'b1;
    restart(); ref_tick = 1'b1;
    wait_pulse(0, 500, n);
    ref_tick = 1'b0;
    @(negedge clk);
    check("R9 swapped ref lead gives down", {pump_up, pump_down}, 2'b01);
    swap_pol = 1'b0;
    @(negedge clk);
    check("R9 unswapped view gives up", {pump_up, pump_down}, 2'b10);

    // R8 coincident pulses
    main_ratio = 17'd4032; ref_ratio = 12'd4032;
    restart(); fb_tick = 1'b1; ref_tick = 1'b1;
    bad = 0;
    repeat (9000) begin
      @(negedge clk);
      if (pump_up || pump_down) bad++;
    end
    check("R8 no pump on coincident edges", bad, 0);

    // R10 power-save silence
    @(negedge clk);
    pwr_on = 1'b0; ref_ratio = 12'd20; fb_tick = 1'b1; ref_tick = 1'b1;
    bad = 0;
    repeat (200) begin
      @(negedge clk);
      if (fb_div || ref_div || pump_up || pump_down) bad++;
    end
    check("R10 quiet in power-save", bad, 0);
    pwr_on = 1'b1;
    wait_pulse(0, 500, n);
    check("R10 first period after wake", n, 20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule